// File: doc/BRIEF.md
# Modem Line Change Monitor

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect). Each input is brought into the clock domain through a two-stage synchronizer. The block shows the present level of every line in a status word. It also records, in one sticky bit per line, that the line has moved since software last looked.

An interrupt request stays high while any sticky bit is set. A read of the status word clears the sticky bits. The same block holds a small control word. That word drives the active-low data-terminal-ready and request-to-send pins and carries the hardware flow-control enable, which is echoed in the status word.

Software reaches both words through a plain register port. The port has a one-bit address (0 = control, 1 = status), a write strobe and a read strobe. Read data is combinational and is valid in the cycle that carries the read strobe. All pins are plain level signals with no handshake.

Top module: `modem_line_monitor`

## Requirements
- R1: Status bits 4, 5, 6 and 7 read as the inverse of the synchronized CTS, DSR, RI and DCD inputs (modem_in[0..3]), in that order.
- R2: Status bits 0 (CTS), 1 (DSR) and 3 (DCD) become 1 after either a rising or a falling transition of their input.
- R3: A status change bit, once set, stays 1 until the status word is read.
- R4: Status bit 2 (RI) becomes 1 only when the RI pin goes from low to high, which is its inactive-going edge. A high-to-low move leaves it 0.
- R5: modem_irq is 1 exactly while at least one of status bits 0 to 3 is 1.
- R6: A read at address 1 clears bits 0 to 3 at the end of that cycle. A change detected in that same cycle leaves its bit set. A read at address 0 clears nothing.
- R7: After a write at address 0, dtr_n equals the inverse of write bit 0 and rts_n equals the inverse of write bit 1.
- R8: Control read-back returns bits 0, 1 and 4 as last written, with all other bits 0. Status bit 8 equals control bit 4 (flow-control enable).
- R9: After reset, the control word is 0, dtr_n and rts_n are 1, modem_irq is 0, and with all inputs high the status word reads 0.
- R10: An input change shows in the status level bits in the second cycle after it is applied, not in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data, combinational |
| modem_in | input | 4 | Raw active-low inputs: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| modem_irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions check the following on every cycle: sticky bits hold, a status read clears them unless a change lands on the same cycle, the RI bit rises only after a low-to-high move of the synchronized line, the interrupt rises only after a detected change, and the pins follow control writes. Other behaviours depend on input timing and can only be shown by the bench scenarios. These are the full sweep of every old-to-new pattern of the four inputs, the exact synchronizer latency, and a change that coincides with a clearing read. The bench also covers control read-back masking and the reset state.

// File: rtl/modem_mon_pkg.sv
package modem_mon_pkg;
  localparam int N_LINES   = 4;
  localparam int REG_W     = 9;
  localparam int SYNC_DEPTH = 2;
  localparam int CB_DTR    = 0;
  localparam int CB_RTS    = 1;
  localparam int CB_FCM    = 4;
  localparam int ST_LVL_LSB = N_LINES;
  localparam int ST_FCM    = 2 * N_LINES;
  localparam logic [N_LINES-1:0] TRAIL_ONLY = 4'b0100;
  localparam logic [N_LINES-1:0] IDLE_LVL   = '1;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

  typedef struct packed {
    logic fcm;
    logic rts;
    logic dtr;
  } ctrl_t;
endpackage

// File: rtl/modem_in_sync.sv
module modem_in_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
  assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/modem_delta_latch.sv
module modem_delta_latch #(
  parameter int W = 4,
  parameter logic [W-1:0] TRAIL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic         clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] delta
);
  for (genvar i = 0; i < W; i++) begin : g_line
    if (TRAIL_MASK[i]) begin : g_trail
      assign hit[i] = rise[i];
    end else begin : g_any
      assign hit[i] = rise[i] | fall[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta <= '0;
    else        delta <= (clr ? '0 : delta) | hit;
  end
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic             dtr_n,
  output logic             rts_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_en) begin
      ctrl.dtr <= wdata[CB_DTR];
      ctrl.rts <= wdata[CB_RTS];
      ctrl.fcm <= wdata[CB_FCM];
    end
  end

  assign dtr_n = ~ctrl.dtr;
  assign rts_n = ~ctrl.rts;
endmodule

// File: rtl/modem_line_monitor.sv
module modem_line_monitor
  import modem_mon_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic         reg_addr,
  input  logic [8:0]   reg_wdata,
  output logic [8:0]   reg_rdata,
  input  logic [3:0]   modem_in,
  output logic         dtr_n,
  output logic         rts_n,
  output logic         modem_irq
);
  logic [N_LINES-1:0] lvl, rise, fall, hit, delta;
  logic               rd_stat, wr_ctrl;
  ctrl_t              ctrl;

  assign rd_stat = reg_rd && (reg_sel_e'(reg_addr) == SEL_STAT);
  assign wr_ctrl = reg_wr && (reg_sel_e'(reg_addr) == SEL_CTRL);

  modem_in_sync #(.W(N_LINES), .STAGES(SYNC_DEPTH), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(modem_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  modem_delta_latch #(.W(N_LINES), .TRAIL_MASK(TRAIL_ONLY)) u_delta (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .clr(rd_stat), .hit(hit), .delta(delta)
  );

  modem_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(reg_wdata),
    .ctrl(ctrl), .dtr_n(dtr_n), .rts_n(rts_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel_e'(reg_addr) == SEL_STAT) begin
      reg_rdata[N_LINES-1:0]               = delta;
      reg_rdata[ST_LVL_LSB +: N_LINES]     = ~lvl;
      reg_rdata[ST_FCM]                    = ctrl.fcm;
    end else begin
      reg_rdata[CB_DTR] = ctrl.dtr;
      reg_rdata[CB_RTS] = ctrl.rts;
      reg_rdata[CB_FCM] = ctrl.fcm;
    end
  end

  assign modem_irq = |delta;
endmodule

// File: rtl/modem_line_monitor_chk.sv
module modem_line_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stat,
  input logic       wr_ctrl,
  input logic [8:0] reg_wdata,
  input logic [3:0] lvl,
  input logic [3:0] rise,
  input logic [3:0] hit,
  input logic [3:0] delta,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       modem_irq
);
  // R3: without a clearing read, set bits never drop
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((delta & $past(delta)) == $past(delta)));

  // R6: a clearing read with no concurrent change leaves all bits 0
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && hit == '0) |=> (delta == '0));

  // R6: a change coincident with the read survives
  p_coincident_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && hit != '0) |=> (delta != '0));

  // R4: RI bit rises only after a low-to-high move of the synced RI line
  p_ri_trailing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta[2]) |-> $past(rise[2]));

  // R5: interrupt rises only after a detected change
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modem_irq) |-> $past(hit != '0));

  // R7: pins follow the control write
  p_pins_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (dtr_n == !$past(reg_wdata[0]) && rts_n == !$past(reg_wdata[1])));
endmodule

bind modem_line_monitor modem_line_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .wr_ctrl(wr_ctrl),
  .reg_wdata(reg_wdata), .lvl(lvl), .rise(rise), .hit(hit), .delta(delta),
  .dtr_n(dtr_n), .rts_n(rts_n), .modem_irq(modem_irq)
);

// File: tb/sim_modem_line_monitor.sv
module sim_modem_line_monitor;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic [3:0] modem_in = 4'hF;
  logic       dtr_n, rts_n, modem_irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_line_monitor u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .modem_in(modem_in), .dtr_n(dtr_n), .rts_n(rts_n), .modem_irq(modem_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic sel, output logic [8:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = sel;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic sel, input logic [8:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [8:0] d;
    logic [3:0] exp_d;
    logic [8:0] exp_s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);
    // R9: reset state
    chk(dtr_n == 1'b1 && rts_n == 1'b1, "R9 pins", {dtr_n, rts_n}, 3);
    chk(modem_irq == 1'b0, "R9 irq", modem_irq, 0);
    do_read(1'b0, d); chk(d == 9'h0, "R9 ctrl", d, 0);
    do_read(1'b1, d); chk(d == 9'h0, "R9 status", d, 0);

    // R2 R4 R1 R5 R3 R6: full sweep of old -> new input patterns
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); modem_in = 4'(a);
        settle(4);
        do_read(1'b1, d);
        @(negedge clk); modem_in = 4'(b);
        settle(5);
        exp_d[0] = a[0] ^ b[0];
        exp_d[1] = a[1] ^ b[1];
        exp_d[2] = !a[2] && b[2];
        exp_d[3] = a[3] ^ b[3];
        chk(modem_irq == (|exp_d), "R5 irq while change set", modem_irq, int'(|exp_d));
        do_read(1'b0, d); // control read must not clear
        do_read(1'b1, d);
        exp_s = {1'b0, ~4'(b), exp_d};
        chk(d[7:4] == exp_s[7:4], "R1 levels", d[7:4], exp_s[7:4]);
        chk({d[3], d[1:0]} == {exp_d[3], exp_d[1:0]}, "R2 R3 any-edge bits",
            {d[3], d[1:0]}, {exp_d[3], exp_d[1:0]});
        chk(d[2] == exp_d[2], "R4 RI trailing edge", d[2], exp_d[2]);
        settle(1);
        chk(modem_irq == 1'b0, "R6 cleared by status read", modem_irq, 0);
      end
    end

    // R10: latency of level bits
    @(negedge clk); modem_in = 4'hF;
    settle(4); do_read(1'b1, d);
    @(negedge clk); modem_in = 4'b1101;
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1;
    #1 chk(reg_rdata[5] == 1'b0, "R10 not yet after one cycle", reg_rdata[5], 0);
    @(negedge clk);
    #1 chk(reg_rdata[5] == 1'b1, "R10 visible after two cycles", reg_rdata[5], 1);
    @(negedge clk); reg_rd = 1'b0;
    settle(3); do_read(1'b1, d);

    // R6: change lands in the same cycle as a clearing read
    @(negedge clk); modem_in = 4'b1110;
    @(negedge clk);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1;
    #1 chk(reg_rdata[0] == 1'b0, "R6 before coincident set", reg_rdata[0], 0);
    @(negedge clk); reg_rd = 1'b0;
    settle(2);
    do_read(1'b1, d);
    chk(d[0] == 1'b1, "R6 coincident change kept", d[0], 1);

    // R7 R8: control word sweep with junk in unused bits
    for (int v = 0; v < 8; v++) begin
      do_write(1'b0, {4'hF, v[2], 2'b11, v[1], v[0]});
      chk(dtr_n == !v[0], "R7 dtr_n", dtr_n, int'(!v[0]));
      chk(rts_n == !v[1], "R7 rts_n", rts_n, int'(!v[1]));
      do_read(1'b0, d);
      exp_s = {4'h0, v[2], 2'b00, v[1], v[0]};
      chk(d == exp_s, "R8 ctrl readback", d, exp_s);
      do_read(1'b1, d);
      chk(d[8] == v[2], "R8 status flow bit", d[8], v[2]);
    end

    settle(2);
    finish_run();
  end
endmodule